// File: doc/BRIEF.md
# Chiplet Control Register File

This block holds a small set of 64-bit control, configuration, status and lock registers behind a plain strobe-based register bus. A requester presents a byte address with a read strobe, a write strobe or both. Every access is a full 64-bit word, and the register index is the byte address with its three low bits dropped.

Each control register and each configuration register can be reached at three indices. The direct index loads the value and reads it back. A set-bits alias ORs the write data into the register. A clear-bits alias removes the bits that are one in the write data. Both aliases are write-only. A read of an alias, a read of an index that holds no register, and any access that is not 8-byte aligned return all ones and raise an error pulse. Writes of those kinds leave every register as it was.

The bus has no back-pressure. The block accepts an access in every cycle. Read data comes back with a valid flag exactly one cycle after the read strobe, so the bus needs no ready signal.

Top module: `chiplet_ctrl_regfile`

## Requirements
- R1: The index is addr[12:3]. Any access with addr[2:0] not zero is rejected: err is high in the next cycle, a write changes no register, and a read returns 64'hFFFF_FFFF_FFFF_FFFF.
- R2: Control registers 0 to 5 sit at indices 0x000 to 0x005. A write to one of these indices loads the data, and a read returns the stored value with err low.
- R3: A write to index 0x010 + n (n = 0 to 5) sets control register n to its old value OR the data, with err low.
- R4: A write to index 0x020 + n sets control register n to its old value AND NOT the data, with err low.
- R5: Configuration registers A and B sit at indices 0x008 and 0x009. Their set-bits aliases are at 0x018 and 0x019, and their clear-bits aliases at 0x028 and 0x029. They follow the semantics of R2 to R4.
- R6: A read of any set-bits or clear-bits alias returns all ones, gives an err pulse and changes no register.
- R7: The status register at index 0x100, the mask register at 0x101, the protect-mode register at 0x3FE and the lock register at 0x3FF are plain read/write registers.
- R8: A read of an index that R2, R5 and R7 do not map returns all ones with err high. A write to such an index gives err high and changes no register.
- R9: rdata and rvalid are registered and appear in the cycle after rd_en. err is a registered single-cycle flag in the cycle after the access. It stays low after a cycle with no access.
- R10: A synchronous active-high reset clears every register, rdata, rvalid and err to zero.
- R11: When rd_en and wr_en are high in the same cycle, the read returns the value from before that write. The write still takes effect, and err is the OR of the read error and the write error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 13 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, valid while rvalid is high |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| err | output | 1 | One-cycle error flag for the access of the previous cycle |

## Verification
Register state is only visible through reads, so the bench keeps a behavioural model of every mapped register and reads each register back after the sequences that change it. A wrong set or clear result therefore shows up on rdata one cycle after the next read of that register. A decode fault that hits the wrong target, or that updates state on an alias read, an unmapped access or a misaligned access, shows up when a neighbouring register is read back. A wrong error classification shows up on err in the very next cycle, because err and rvalid are compared against the model on every clock.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [1:0] {
    SC_HOLD = 2'd0,
    SC_LOAD = 2'd1,
    SC_SET  = 2'd2,
    SC_CLR  = 2'd3
  } sc_op_e;

  typedef enum logic [1:0] {
    HIT_NONE   = 2'd0,
    HIT_DIRECT = 2'd1,
    HIT_ALIAS  = 2'd2
  } hit_e;

  localparam int SET_OFS = 'h10;
  localparam int CLR_OFS = 'h20;
  localparam logic [63:0] PLAIN_IDX_DEF = {16'h03FF, 16'h03FE, 16'h0101, 16'h0100};
endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int NCTRL    = 6,
  parameter int NCFG     = 2,
  parameter int CFG_BASE = 8,
  parameter int NPLAIN   = 4,
  parameter logic [NPLAIN*16-1:0] PLAIN_IDX = PLAIN_IDX_DEF,
  localparam int NSC     = NCTRL + NCFG,
  localparam int IDX_W   = ADDR_W - 3
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_e              hit,
  output sc_op_e            sc_op,
  output logic [NSC-1:0]    sc_sel,
  output logic [NPLAIN-1:0] pl_sel
);
  logic [IDX_W-1:0] idx;
  logic             aligned;

  function automatic int sc_base(input int j);
    return (j < NCTRL) ? j : CFG_BASE + (j - NCTRL);
  endfunction

  assign idx     = addr[ADDR_W-1:3];
  assign aligned = (addr[2:0] == 3'b000);

  always_comb begin
    hit    = HIT_NONE;
    sc_op  = SC_HOLD;
    sc_sel = '0;
    pl_sel = '0;
    if (aligned) begin
      for (int j = 0; j < NSC; j++) begin
        if (int'(idx) == sc_base(j)) begin
          sc_sel[j] = 1'b1;
          sc_op     = SC_LOAD;
          hit       = HIT_DIRECT;
        end else if (int'(idx) == sc_base(j) + SET_OFS) begin
          sc_sel[j] = 1'b1;
          sc_op     = SC_SET;
          hit       = HIT_ALIAS;
        end else if (int'(idx) == sc_base(j) + CLR_OFS) begin
          sc_sel[j] = 1'b1;
          sc_op     = SC_CLR;
          hit       = HIT_ALIAS;
        end
      end
      for (int k = 0; k < NPLAIN; k++) begin
        if (int'(idx) == int'(PLAIN_IDX[k*16 +: 16])) begin
          pl_sel[k] = 1'b1;
          hit       = HIT_DIRECT;
        end
      end
    end
  end
endmodule

// File: rtl/ccr_sc_reg.sv
module ccr_sc_reg
  import ccr_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  sc_op_e        op,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      unique case (op)
        SC_LOAD: q <= wdata;
        SC_SET:  q <= q | wdata;
        SC_CLR:  q <= q & ~wdata;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/ccr_rdmux.sv
module ccr_rdmux
  import ccr_pkg::*;
#(
  parameter int DW     = 64,
  parameter int NSC    = 8,
  parameter int NPLAIN = 4
) (
  input  hit_e                         hit,
  input  logic [NSC-1:0]               sc_sel,
  input  logic [NSC-1:0][DW-1:0]       sc_q,
  input  logic [NPLAIN-1:0]            pl_sel,
  input  logic [NPLAIN-1:0][DW-1:0]    pl_q,
  output logic [DW-1:0]                rd_val,
  output logic                         rd_bad
);
  logic [DW-1:0] picked;

  always_comb begin
    picked = '0;
    for (int j = 0; j < NSC; j++)
      if (sc_sel[j]) picked = picked | sc_q[j];
    for (int k = 0; k < NPLAIN; k++)
      if (pl_sel[k]) picked = picked | pl_q[k];
  end

  assign rd_bad = (hit != HIT_DIRECT);
  assign rd_val = rd_bad ? '1 : picked;
endmodule

// File: rtl/chiplet_ctrl_regfile.sv
module chiplet_ctrl_regfile
  import ccr_pkg::*;
#(
  parameter int DW       = 64,
  parameter int ADDR_W   = 13,
  parameter int NCTRL    = 6,
  parameter int NCFG     = 2,
  parameter int CFG_BASE = 8,
  parameter int NPLAIN   = 4,
  parameter logic [NPLAIN*16-1:0] PLAIN_IDX = PLAIN_IDX_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              rvalid,
  output logic              err
);
  localparam int NSC = NCTRL + NCFG;

  hit_e                      hit;
  sc_op_e                    sc_op;
  logic [NSC-1:0]            sc_sel;
  logic [NPLAIN-1:0]         pl_sel;
  logic [NSC-1:0][DW-1:0]    sc_q;
  logic [NPLAIN-1:0][DW-1:0] pl_q;
  logic [DW-1:0]             rd_val;
  logic                      rd_bad;
  logic                      wr_bad;

  ccr_decode #(
    .ADDR_W(ADDR_W), .NCTRL(NCTRL), .NCFG(NCFG), .CFG_BASE(CFG_BASE),
    .NPLAIN(NPLAIN), .PLAIN_IDX(PLAIN_IDX)
  ) u_dec (
    .addr(addr), .hit(hit), .sc_op(sc_op), .sc_sel(sc_sel), .pl_sel(pl_sel)
  );

  for (genvar j = 0; j < NSC; j++) begin : g_sc
    ccr_sc_reg #(.DW(DW)) u_reg (
      .clk(clk), .rst(rst), .en(wr_en && sc_sel[j]), .op(sc_op),
      .wdata(wdata), .q(sc_q[j])
    );
  end

  for (genvar k = 0; k < NPLAIN; k++) begin : g_pl
    ccr_sc_reg #(.DW(DW)) u_reg (
      .clk(clk), .rst(rst), .en(wr_en && pl_sel[k]), .op(SC_LOAD),
      .wdata(wdata), .q(pl_q[k])
    );
  end

  ccr_rdmux #(.DW(DW), .NSC(NSC), .NPLAIN(NPLAIN)) u_mux (
    .hit(hit), .sc_sel(sc_sel), .sc_q(sc_q), .pl_sel(pl_sel), .pl_q(pl_q),
    .rd_val(rd_val), .rd_bad(rd_bad)
  );

  assign wr_bad = (hit == HIT_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rvalid <= rd_en;
      err    <= (rd_en && rd_bad) || (wr_en && wr_bad);
      if (rd_en) rdata <= rd_val;
    end
  end
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
  parameter int DW     = 64,
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DW-1:0]     rdata,
  input logic              rvalid,
  input logic              err
);
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid); // R9
  AST_NO_RVALID_WITHOUT_READ: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rvalid); // R9
  AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    !(rd_en || wr_en) |=> !err); // R9
  AST_MISALIGNED_ERR: assert property (@(posedge clk) disable iff (rst)
    ((rd_en || wr_en) && addr[2:0] != 3'b000) |=> err); // R1
  AST_READ_ERR_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> (!err || (&rdata))); // R8
  AST_ALIAS_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[2:0] == 3'b000 && addr[ADDR_W-1:3] == (ADDR_W-3)'('h12)) |=> (err && (&rdata))); // R6
  AST_UNMAPPED_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[2:0] == 3'b000 && addr[ADDR_W-1:3] == (ADDR_W-3)'('h3FD)) |=> (err && (&rdata))); // R8
endmodule

bind chiplet_ctrl_regfile ccr_checker #(.DW(DW), .ADDR_W(ADDR_W)) u_ccr_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .rvalid(rvalid), .err(err)
);

// File: tb/chiplet_ctrl_regfile_bench.sv
module chiplet_ctrl_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        rvalid;
  logic        err;

  int checks = 0;
  int failures = 0;
  bit armed = 0;
  bit done = 0;
  string cur_tag = "R10";

  logic [63:0] m [int];
  logic        exp_rv = 0;
  logic        exp_err = 0;
  logic [63:0] exp_rd = '0;
  string       exp_tag = "R10";

  int mapped [12] = '{'h0, 'h1, 'h2, 'h3, 'h4, 'h5, 'h8, 'h9, 'h100, 'h101, 'h3FE, 'h3FF};

  always #2 clk = ~clk;

  chiplet_ctrl_regfile u_chiplet_ctrl_regfile (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err(err)
  );

  function automatic bit is_sc(int i);
    return (i >= 0 && i <= 5) || i == 8 || i == 9;
  endfunction

  function automatic bit is_pl(int i);
    return i == 'h100 || i == 'h101 || i == 'h3FE || i == 'h3FF;
  endfunction

  // 0 unmapped, 1 direct, 2 set alias, 3 clear alias
  function automatic int cls(int i, output int tgt);
    tgt = i;
    if (is_sc(i) || is_pl(i)) return 1;
    if (i >= 'h10 && is_sc(i - 'h10)) begin tgt = i - 'h10; return 2; end
    if (i >= 'h20 && is_sc(i - 'h20)) begin tgt = i - 'h20; return 3; end
    return 0;
  endfunction

  task automatic model_clear();
    foreach (mapped[i]) m[mapped[i]] = '0;
  endtask

  int c_m, t_m;
  logic rb_m, wb_m;
  logic [63:0] rv_m;

  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      model_clear();
      exp_rv  <= 1'b0;
      exp_err <= 1'b0;
      exp_rd  <= '0;
    end else begin
      t_m = 0;
      c_m = (addr[2:0] == 3'b000) ? cls(int'(addr[12:3]), t_m) : 0;
      rb_m = 1'b0;
      wb_m = 1'b0;
      rv_m = '1;
      if (rd_en) begin
        if (c_m == 1) rv_m = m[t_m];
        else rb_m = 1'b1;
      end
      if (wr_en) begin
        case (c_m)
          1: m[t_m] = wdata;
          2: m[t_m] = m[t_m] | wdata;
          3: m[t_m] = m[t_m] & ~wdata;
          default: wb_m = 1'b1;
        endcase
      end
      exp_rv  <= rd_en;
      exp_err <= (rd_en && rb_m) || (wr_en && wb_m);
      if (rd_en) exp_rd <= rv_m;
    end
    exp_tag <= cur_tag;
  end

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk(rvalid === exp_rv, exp_tag, "rvalid", 64'(rvalid), 64'(exp_rv));
      chk(err === exp_err, exp_tag, "err", 64'(err), 64'(exp_err));
      if (exp_rv) chk(rdata === exp_rd, exp_tag, "rdata", rdata, exp_rd);
    end
  end

  function automatic logic [12:0] A(int i);
    return 13'(i << 3);
  endfunction

  task automatic op(bit rd, bit wr, logic [12:0] a, logic [63:0] d, string tag);
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; wdata = d; cur_tag = tag;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op(0, 0, '0, '0, "R9");
  endtask

  task automatic read_all(string tag);
    foreach (mapped[i]) op(1, 0, A(mapped[i]), '0, tag);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 50000, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(rdata === '0 && !rvalid && !err, "R10", "reset outputs",
        {rdata[61:0], rvalid, err}, '0);
    read_all("R10");
    // R2 direct control loads
    for (int k = 0; k < 6; k++) op(0, 1, A(k), 64'h0123_4567_89AB_CDEF ^ (64'(k) << 40), "R2");
    for (int k = 0; k < 6; k++) op(1, 0, A(k), '0, "R2");
    // R3 set-bits aliases
    op(0, 1, A('h12), 64'hF000_0000_0000_00F0, "R3");
    op(1, 0, A(2), '0, "R3");
    op(0, 1, A('h15), 64'hFFFF_0000_0000_0000, "R3");
    op(1, 0, A(5), '0, "R3");
    // R4 clear-bits aliases
    op(0, 1, A('h22), 64'h0000_0000_FFFF_0000, "R4");
    op(1, 0, A(2), '0, "R4");
    op(0, 1, A('h20), 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    op(1, 0, A(0), '0, "R4");
    // R5 configuration registers
    op(0, 1, A('h08), 64'hAAAA_5555_AAAA_5555, "R5");
    op(0, 1, A('h18), 64'h0000_FFFF_0000_0000, "R5");
    op(0, 1, A('h28), 64'h0000_0000_0000_00FF, "R5");
    op(1, 0, A('h08), '0, "R5");
    op(0, 1, A('h09), 64'h1, "R5");
    op(0, 1, A('h19), 64'h8000_0000_0000_0000, "R5");
    op(0, 1, A('h29), 64'h1, "R5");
    op(1, 0, A('h09), '0, "R5");
    // R6 alias reads
    op(1, 0, A('h10), '0, "R6");
    op(1, 0, A('h15), '0, "R6");
    op(1, 0, A('h20), '0, "R6");
    op(1, 0, A('h25), '0, "R6");
    op(1, 0, A('h18), '0, "R6");
    op(1, 0, A('h29), '0, "R6");
    read_all("R6");
    // R7 plain registers
    op(0, 1, A('h100), 64'hDEAD_BEEF_0000_0001, "R7");
    op(0, 1, A('h101), 64'h0000_FFFF_0000_FFFF, "R7");
    op(0, 1, A('h3FE), 64'h8000_0000_0000_0000, "R7");
    op(0, 1, A('h3FF), 64'h0000_0000_0000_0001, "R7");
    op(1, 0, A('h100), '0, "R7");
    op(1, 0, A('h101), '0, "R7");
    op(1, 0, A('h3FE), '0, "R7");
    op(1, 0, A('h3FF), '0, "R7");
    // R8 unmapped indices
    op(1, 0, A('h06), '0, "R8");
    op(1, 0, A('h0A), '0, "R8");
    op(1, 0, A('h16), '0, "R8");
    op(1, 0, A('h2A), '0, "R8");
    op(1, 0, A('h30), '0, "R8");
    op(1, 0, A('h102), '0, "R8");
    op(1, 0, A('h3FD), '0, "R8");
    op(1, 0, A('h110), '0, "R8");
    op(0, 1, A('h06), 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    op(0, 1, A('h0A), 64'h1234, "R8");
    op(0, 1, A('h110), 64'h5678, "R8");
    op(0, 1, A('h3FD), 64'h9ABC, "R8");
    read_all("R8");
    // R1 misaligned accesses
    op(0, 1, A(0) + 13'd4, 64'h5A5A_5A5A_5A5A_5A5A, "R1");
    op(0, 1, A('h100) + 13'd1, 64'h0, "R1");
    op(1, 0, A(1) + 13'd2, '0, "R1");
    op(1, 0, A(0), '0, "R1");
    op(1, 0, A('h100), '0, "R1");
    // R11 read and write in the same cycle
    op(1, 1, A(3), 64'hCAFE_F00D_0000_0003, "R11");
    op(1, 0, A(3), '0, "R11");
    op(1, 1, A('h13), 64'h00F0, "R11");
    op(1, 1, A(4), 64'h77, "R11");
    op(1, 0, A(4), '0, "R11");
    // R9 strobe timing
    op(1, 0, A(1), '0, "R9");
    idle(1);
    op(0, 1, A(1), 64'h42, "R9");
    idle(2);
    op(1, 0, A(1), '0, "R9");
    op(1, 0, A('h9), '0, "R9");
    idle(2);
    // R2 mixed random traffic
    for (int n = 0; n < 400; n++) begin
      int sel;
      int idx;
      logic [12:0] a;
      sel = $urandom_range(0, 19);
      if (sel < 12) idx = mapped[sel];
      else if (sel < 16) idx = 'h10 + ((sel < 14) ? $urandom_range(0, 5) : 8 + sel - 14);
      else if (sel < 18) idx = 'h20 + $urandom_range(0, 9);
      else idx = $urandom_range(0, 'h3FF);
      a = A(idx);
      if ($urandom_range(0, 15) == 0) a[2:0] = 3'($urandom_range(1, 7));
      op($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a,
         {$urandom, $urandom}, "R2");
    end
    read_all("R2");
    // R10 reset in the middle of traffic
    @(negedge clk);
    rst = 1'b1; rd_en = 0; wr_en = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(rdata === '0 && !rvalid && !err, "R10", "reset outputs",
        {rdata[61:0], rvalid, err}, '0);
    read_all("R10");
    idle(3);
    finish_run();
  end
endmodule